// File: doc/BRIEF.md
# QDR II SRAM Request Sequencer

This block sits between a user-side request interface and the command pins of a QDR II SRAM. The user raises active-low read and write requests, each with its own address. A write request also carries a data word four device beats wide and an active-low byte mask of matching width. Each request is held in a small per-port queue. Both queues expose a full flag, and a request that arrives while its flag is high is dropped. The sequencer drains the queues into device commands: an active-low read-port select, an active-low write-port select, and one shared address bus. The write word is cut into device-width beats for the double-data-rate write channel.

Every output is registered. The double-data-rate output registers are modelled as separate rising-edge and falling-edge outputs for the address, the write data and the byte-write selects. A parameter chooses burst-of-2 or burst-of-4 operation. In burst-of-2 operation one user word becomes two device accesses at addresses `{A,0}` and `{A,1}`, and read and write commands share the address bus on opposite clock phases. In burst-of-4 operation one user word is one device access, and read and write commands alternate on the rising-edge address. Clock generation, phase shifting, I/O cells and read capture belong to other blocks.

Top module: `qdr_req_seq`

## Requirements
- R1: While `rst` is high and in the first clock after it falls, both selects are high, every byte-write select is high, write data is zero and both full flags are low. Requests presented while `rst` is high are discarded.
- R2: In burst-of-2 mode, a write request accepted at clock edge k drives `wps_n` low after edges k+1 and k+2. During those two clocks `addr_f` carries `{A,0}` and then `{A,1}`.
- R3: Write beat i (i = 0..3) is `wr_data[DW*i +: DW]`, sent least significant first. The even beat goes out on `d_r` and the odd beat on `d_f`, two beats per clock. The byte-write selects for beat i are `wr_bmask_n[NB*i +: NB]`, where NB is 2 for an 18-bit device and 1 otherwise. They appear on `bws_r_n` / `bws_f_n` together with that beat.
- R4: In burst-of-2 mode, a read request accepted at edge k drives `rps_n` low after edges k+1 and k+2. During those two clocks `addr_r` carries `{A,0}` and then `{A,1}`.
- R5: In burst-of-2 mode, a read and a write accepted at the same edge are issued in the same two clocks, the read on `addr_r` and the write on `addr_f`.
- R6: In burst-of-4 mode, a request accepted at edge k issues one command after edge k+1 with `addr_r` = A, and `addr_f` stays zero. A write sends beats 0 and 1 in that clock and beats 2 and 3 in the next clock. The same port issues no command in that second clock.
- R7: In burst-of-4 mode, `rps_n` and `wps_n` are never low together. When a read and a write become ready in the same clock, the read is issued first and the write one clock later.
- R8: A queue's full flag is high when that queue holds its full depth of entries. A request presented while the flag is high is dropped. Accepted requests are issued in acceptance order.
- R9: When no command is issued, the select is high and its address output is zero. When no write beat is sent, every byte-write select is high and the write data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_n | input | 1 | Active-low read request |
| rd_addr | input | UAW | Read user address |
| wr_req_n | input | 1 | Active-low write request |
| wr_addr | input | UAW | Write user address |
| wr_data | input | 4*DW | Write word, four device beats |
| wr_bmask_n | input | 4*NB | Active-low byte mask, NB bits per beat |
| wr_full | output | 1 | Write queue full |
| rd_full | output | 1 | Read queue full |
| rps_n | output | 1 | Active-low read-port select |
| wps_n | output | 1 | Active-low write-port select |
| addr_r | output | DAW | Address launched on the rising edge |
| addr_f | output | DAW | Address launched on the falling edge (burst-of-2 writes) |
| d_r | output | DW | Write beat on the rising edge |
| d_f | output | DW | Write beat on the falling edge |
| bws_r_n | output | NB | Byte-write selects for the rising beat |
| bws_f_n | output | NB | Byte-write selects for the falling beat |

## Verification
The half-beat counter of a port decides both the low address bit and which pair of beats is sent. If that state is wrong, the low address bit repeats or the beat order swaps, and this shows in the first clock after the command starts. A wrong queue count shows within a few clocks of a burst of requests. It appears as a full flag that never rises or as a dropped or duplicated address in the command stream. In burst-of-4 mode, a wrong tie-break or a missed data phase puts both selects low together, or starts a write on the clock that should carry its second beat pair. That error is visible one clock after the two requests arrive.

// File: rtl/qdr_seq_pkg.sv
package qdr_seq_pkg;

  // Byte-write lanes per device beat: two 9-bit lanes on an 18-bit device.
  function automatic int lanes_for(input int dw);
    return (dw == 18) ? 2 : 1;
  endfunction

endpackage

// File: rtl/qdr_req_fifo.sv
module qdr_req_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             wr_en, rd_en;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_en = push & ~full;
  assign rd_en = pop & ~empty;
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rptr];

  // Storage without reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= step(wptr);
      if (rd_en) rptr <= step(rptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8
  fifo_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);

  // R8
  fifo_pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/qdr_cmd_arb.sv
module qdr_cmd_arb #(
  parameter int BURST = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wq_empty,
  input  logic rq_empty,
  output logic wr_cmd,
  output logic wr_beat,
  output logic wr_pop,
  output logic rd_cmd,
  output logic rd_pop
);
  // Each user word occupies its port for two clocks; the sub flag marks the
  // second clock, which also retires the queue head.
  logic wsub, rsub;
  logic rd_act;

  assign wr_pop = wsub;
  assign rd_pop = rsub;

  generate
    if (BURST == 4) begin : g_b4
      logic rd_start, wr_start;
      assign rd_start = ~rsub & ~rq_empty;
      assign wr_start = ~wsub & ~wq_empty & ~rd_start;
      assign rd_cmd   = rd_start;
      assign wr_cmd   = wr_start;
      assign rd_act   = rd_start | rsub;
      assign wr_beat  = wr_start | wsub;

      // R6
      b4_wr_data_phase_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> (wr_beat && !wr_cmd));
    end else begin : g_b2
      assign rd_act  = rsub | ~rq_empty;
      assign wr_beat = wsub | ~wq_empty;
      assign rd_cmd  = rd_act;
      assign wr_cmd  = wr_beat;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wsub <= 1'b0;
      rsub <= 1'b0;
    end else begin
      wsub <= wr_beat & ~wsub;
      rsub <= rd_act & ~rsub;
    end
  end

endmodule

// File: rtl/qdr_beat_out.sv
module qdr_beat_out #(
  parameter int DW = 18,
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            beat_en,
  input  logic            half,
  input  logic [4*DW-1:0] word,
  input  logic [4*NB-1:0] mask_n,
  output logic [DW-1:0]   d_r,
  output logic [DW-1:0]   d_f,
  output logic [NB-1:0]   bws_r_n,
  output logic [NB-1:0]   bws_f_n
);
  logic [2*DW-1:0] pair;
  logic [2*NB-1:0] pmask;

  // First clock: beats 0/1; second clock: beats 2/3.
  assign pair  = half ? word[4*DW-1:2*DW] : word[2*DW-1:0];
  assign pmask = half ? mask_n[4*NB-1:2*NB] : mask_n[2*NB-1:0];

  always_ff @(posedge clk) begin
    if (rst || !beat_en) begin
      d_r     <= '0;
      d_f     <= '0;
      bws_r_n <= '1;
      bws_f_n <= '1;
    end else begin
      d_r     <= pair[DW-1:0];
      d_f     <= pair[2*DW-1:DW];
      bws_r_n <= pmask[NB-1:0];
      bws_f_n <= pmask[2*NB-1:NB];
    end
  end

  // R9
  idle_bws_high_chk: assert property (@(posedge clk) disable iff (rst)
    !beat_en |=> (&bws_r_n && &bws_f_n));

endmodule

// File: rtl/qdr_req_seq.sv
module qdr_req_seq #(
  parameter int DW       = 18,
  parameter int BURST    = 2,
  parameter int UAW      = 8,
  parameter int WQ_DEPTH = 4,
  parameter int RQ_DEPTH = 4,
  localparam int NB  = qdr_seq_pkg::lanes_for(DW),
  localparam int UW  = 4 * DW,
  localparam int MW  = 4 * NB,
  localparam int DAW = UAW + ((BURST == 2) ? 1 : 0)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_req_n,
  input  logic [UAW-1:0] rd_addr,
  input  logic           wr_req_n,
  input  logic [UAW-1:0] wr_addr,
  input  logic [UW-1:0]  wr_data,
  input  logic [MW-1:0]  wr_bmask_n,
  output logic           wr_full,
  output logic           rd_full,
  output logic           rps_n,
  output logic           wps_n,
  output logic [DAW-1:0] addr_r,
  output logic [DAW-1:0] addr_f,
  output logic [DW-1:0]  d_r,
  output logic [DW-1:0]  d_f,
  output logic [NB-1:0]  bws_r_n,
  output logic [NB-1:0]  bws_f_n
);
  localparam int WQW = UAW + MW + UW;

  logic [WQW-1:0] wq_head;
  logic [UAW-1:0] rq_head, wq_addr;
  logic [MW-1:0]  wq_mask;
  logic [UW-1:0]  wq_data;
  logic           wq_empty, rq_empty;
  logic           wr_cmd, wr_beat, wr_pop, rd_cmd, rd_pop;
  logic [DAW-1:0] addr_r_nx, addr_f_nx;
  logic           rst_q;

  qdr_req_fifo #(.WIDTH(WQW), .DEPTH(WQ_DEPTH)) wq_i (
    .clk(clk), .rst(rst), .push(~wr_req_n & ~rst), .pop(wr_pop),
    .din({wr_addr, wr_bmask_n, wr_data}), .head(wq_head),
    .full(wr_full), .empty(wq_empty));

  qdr_req_fifo #(.WIDTH(UAW), .DEPTH(RQ_DEPTH)) rq_i (
    .clk(clk), .rst(rst), .push(~rd_req_n & ~rst), .pop(rd_pop),
    .din(rd_addr), .head(rq_head), .full(rd_full), .empty(rq_empty));

  assign {wq_addr, wq_mask, wq_data} = wq_head;

  qdr_cmd_arb #(.BURST(BURST)) arb_i (
    .clk(clk), .rst(rst), .wq_empty(wq_empty), .rq_empty(rq_empty),
    .wr_cmd(wr_cmd), .wr_beat(wr_beat), .wr_pop(wr_pop),
    .rd_cmd(rd_cmd), .rd_pop(rd_pop));

  // The pop flag doubles as the half indicator (second clock of a word).
  qdr_beat_out #(.DW(DW), .NB(NB)) beat_i (
    .clk(clk), .rst(rst), .beat_en(wr_beat), .half(wr_pop),
    .word(wq_data), .mask_n(wq_mask),
    .d_r(d_r), .d_f(d_f), .bws_r_n(bws_r_n), .bws_f_n(bws_f_n));

  generate
    if (BURST == 2) begin : g_addr_b2
      assign addr_r_nx = rd_cmd ? {rq_head, rd_pop} : '0;
      assign addr_f_nx = wr_cmd ? {wq_addr, wr_pop} : '0;

      // R2
      b2_wr_second_half_chk: assert property (@(posedge clk) disable iff (rst)
        (!wps_n && !addr_f[0]) |=> (!wps_n && addr_f[0]));

      // R4
      b2_rd_second_half_chk: assert property (@(posedge clk) disable iff (rst)
        (!rps_n && !addr_r[0]) |=> (!rps_n && addr_r[0]));
    end else begin : g_addr_b4
      assign addr_r_nx = rd_cmd ? rq_head : (wr_cmd ? wq_addr : '0);
      assign addr_f_nx = '0;

      // R7
      b4_single_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rps_n && !wps_n));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rps_n  <= 1'b1;
      wps_n  <= 1'b1;
      addr_r <= '0;
      addr_f <= '0;
    end else begin
      rps_n  <= ~rd_cmd;
      wps_n  <= ~wr_cmd;
      addr_r <= addr_r_nx;
      addr_f <= addr_f_nx;
    end
  end

  always_ff @(posedge clk) rst_q <= rst;

  // R1
  sel_idle_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (rps_n && wps_n));

endmodule

// File: tb/qdr_req_seq_tb_top.sv
module qdr_req_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 18;
  localparam int UAW = 8;

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 read, 2 both
    logic [7:0]  ra;
    logic [7:0]  wa;
    logic [71:0] data;
    logic [7:0]  mask;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 8'h00, 8'h12, 72'h1A2B3C4D5E6F708192, 8'hA5},
    '{2'd1, 8'h34, 8'h00, 72'h0, 8'hFF},
    '{2'd2, 8'h7F, 8'h80, 72'hFEDCBA987654321012, 8'h3C},
    '{2'd0, 8'h00, 8'hFF, 72'h0000003FFFF0000001, 8'h00},
    '{2'd2, 8'h00, 8'hFF, 72'h5A5A5A5A5A5A5A5A5A, 8'hF0},
    '{2'd1, 8'hFF, 8'h00, 72'h0, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req_n = 1'b1, wr_req_n = 1'b1;
  logic [7:0]  rd_addr = '0, wr_addr = '0;
  logic [71:0] wr_data = '0;
  logic [7:0]  wr_bmask_n = '1;

  logic wr_full2, rd_full2, rps2_n, wps2_n;
  logic [8:0] ar2, af2;
  logic [17:0] dr2, df2;
  logic [1:0] br2, bf2;
  logic wr_full4, rd_full4, rps4_n, wps4_n;
  logic [7:0] ar4, af4;
  logic [17:0] dr4, df4;
  logic [1:0] br4, bf4;

  int nchk = 0, nfail = 0;
  logic done = 1'b0;
  logic log_clr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdr_req_seq #(.DW(DW), .BURST(2), .UAW(UAW)) dut_i (
    .clk(clk), .rst(rst), .rd_req_n(rd_req_n), .rd_addr(rd_addr),
    .wr_req_n(wr_req_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bmask_n(wr_bmask_n), .wr_full(wr_full2), .rd_full(rd_full2),
    .rps_n(rps2_n), .wps_n(wps2_n), .addr_r(ar2), .addr_f(af2),
    .d_r(dr2), .d_f(df2), .bws_r_n(br2), .bws_f_n(bf2));

  qdr_req_seq #(.DW(DW), .BURST(4), .UAW(UAW)) dut4_i (
    .clk(clk), .rst(rst), .rd_req_n(rd_req_n), .rd_addr(rd_addr),
    .wr_req_n(wr_req_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bmask_n(wr_bmask_n), .wr_full(wr_full4), .rd_full(rd_full4),
    .rps_n(rps4_n), .wps_n(wps4_n), .addr_r(ar4), .addr_f(af4),
    .d_r(dr4), .d_f(df4), .bws_r_n(br4), .bws_f_n(bf4));

  // Command logs: user addresses of issued commands, in issue order.
  logic [7:0] lw2 [64], lr2 [64], lw4 [64], lr4 [64];
  int nlw2 = 0, nlr2 = 0, nlw4 = 0, nlr4 = 0;

  always @(negedge clk) begin
    if (log_clr) begin
      nlw2 = 0; nlr2 = 0; nlw4 = 0; nlr4 = 0;
    end else begin
      if (!wps2_n && !af2[0] && nlw2 < 64) begin lw2[nlw2] = af2[8:1]; nlw2++; end
      if (!rps2_n && !ar2[0] && nlr2 < 64) begin lr2[nlr2] = ar2[8:1]; nlr2++; end
      if (!wps4_n && nlw4 < 64) begin lw4[nlw4] = ar4; nlw4++; end
      if (!rps4_n && nlr4 < 64) begin lr4[nlr4] = ar4; nlr4++; end
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] beat(input logic [71:0] d, input int i);
    return (i >= 0 && i < 4) ? d[i*18 +: 18] : 18'h0;
  endfunction

  function automatic logic [1:0] bmask(input logic [7:0] m, input int i);
    return (i >= 0 && i < 4) ? m[i*2 +: 2] : 2'b11;
  endfunction

  task automatic check_b2(input vec_t v, input int s);
    logic hw, hr, act;
    string tw, tr;
    hw  = (v.kind != 2'd1);
    hr  = (v.kind != 2'd0);
    act = (s < 2);
    tw  = !act ? "R9" : (v.kind == 2'd2 ? "R5" : "R2");
    tr  = !act ? "R9" : (v.kind == 2'd2 ? "R5" : "R4");
    chk({tw, " b2 wps_n"},  wps2_n, !(hw && act));
    chk({tw, " b2 addr_f"}, af2, (hw && act) ? {v.wa, s[0]} : 9'h0);
    chk({tr, " b2 rps_n"},  rps2_n, !(hr && act));
    chk({tr, " b2 addr_r"}, ar2, (hr && act) ? {v.ra, s[0]} : 9'h0);
    chk(act ? "R3 b2 d_r" : "R9 b2 d_r", dr2, (hw && act) ? beat(v.data, 2*s) : 18'h0);
    chk(act ? "R3 b2 d_f" : "R9 b2 d_f", df2, (hw && act) ? beat(v.data, 2*s+1) : 18'h0);
    chk(act ? "R3 b2 bws_r_n" : "R9 b2 bws_r_n", br2, (hw && act) ? bmask(v.mask, 2*s) : 2'b11);
    chk(act ? "R3 b2 bws_f_n" : "R9 b2 bws_f_n", bf2, (hw && act) ? bmask(v.mask, 2*s+1) : 2'b11);
  endtask

  task automatic check_b4(input vec_t v, input int s);
    logic hw, hr, wcmd, rcmd, wdat;
    int wofs, p;
    string tg;
    hw   = (v.kind != 2'd1);
    hr   = (v.kind != 2'd0);
    wofs = (v.kind == 2'd2) ? 1 : 0;
    p    = s - wofs;
    wcmd = hw && (p == 0);
    wdat = hw && (p == 0 || p == 1);
    rcmd = hr && (s == 0);
    tg   = (v.kind == 2'd2) ? "R7" : "R6";
    chk({tg, " b4 wps_n"},  wps4_n, !wcmd);
    chk({tg, " b4 rps_n"},  rps4_n, !rcmd);
    chk({tg, " b4 addr_r"}, ar4, rcmd ? v.ra : (wcmd ? v.wa : 8'h0));
    chk("R6 b4 addr_f", af4, 8'h0);
    chk("R3 b4 d_r", dr4, wdat ? beat(v.data, 2*p) : 18'h0);
    chk("R3 b4 d_f", df4, wdat ? beat(v.data, 2*p+1) : 18'h0);
    chk("R3 b4 bws_r_n", br4, wdat ? bmask(v.mask, 2*p) : 2'b11);
    chk("R3 b4 bws_f_n", bf4, wdat ? bmask(v.mask, 2*p+1) : 2'b11);
  endtask

  logic [7:0] ew2 [16], er2 [16], ew4 [16], er4 [16];
  int new2, ner2, new4, ner4;
  logic full_seen;

  initial begin
    // Reset with requests held active: they must be discarded (R1).
    @(negedge clk);
    rd_req_n = 1'b0; wr_req_n = 1'b0; rd_addr = 8'h11; wr_addr = 8'h22;
    repeat (3) @(negedge clk);
    chk("R1 b2 rps_n", rps2_n, 1'b1);
    chk("R1 b2 wps_n", wps2_n, 1'b1);
    chk("R1 b2 bws", {br2, bf2}, 4'hF);
    chk("R1 b2 d", {dr2, df2}, 36'h0);
    chk("R1 b2 flags", {wr_full2, rd_full2}, 2'b00);
    chk("R1 b4 sel", {rps4_n, wps4_n}, 2'b11);
    chk("R1 b4 flags", {wr_full4, rd_full4}, 2'b00);
    rst = 1'b0; rd_req_n = 1'b1; wr_req_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 b2 no cmd after reset", {rps2_n, wps2_n}, 2'b11);
      chk("R1 b4 no cmd after reset", {rps4_n, wps4_n}, 2'b11);
      chk("R1 b2 bws after reset", {br2, bf2}, 4'hF);
    end

    // Vector table.
    foreach (VECS[k]) begin
      rd_req_n   = !(VECS[k].kind != 2'd0);
      wr_req_n   = !(VECS[k].kind != 2'd1);
      rd_addr    = VECS[k].ra;
      wr_addr    = VECS[k].wa;
      wr_data    = VECS[k].data;
      wr_bmask_n = VECS[k].mask;
      @(negedge clk);
      rd_req_n = 1'b1; wr_req_n = 1'b1;
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        check_b2(VECS[k], s);
        check_b4(VECS[k], s);
      end
    end

    // Queue fill: hold both requests for 12 clocks (R8).
    @(posedge clk); log_clr = 1'b1;
    @(posedge clk); log_clr = 1'b0;
    @(negedge clk);
    new2 = 0; ner2 = 0; new4 = 0; ner4 = 0; full_seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      wr_req_n = 1'b0; rd_req_n = 1'b0;
      wr_addr = 8'h40 + 8'(i); rd_addr = 8'h60 + 8'(i);
      wr_data = {4{18'(i)}}; wr_bmask_n = 8'h00;
      if (!wr_full2) begin ew2[new2] = wr_addr; new2++; end
      if (!rd_full2) begin er2[ner2] = rd_addr; ner2++; end
      if (!wr_full4) begin ew4[new4] = wr_addr; new4++; end
      if (!rd_full4) begin er4[ner4] = rd_addr; ner4++; end
      if (wr_full2 || rd_full2) full_seen = 1'b1;
      @(negedge clk);
    end
    wr_req_n = 1'b1; rd_req_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 full flag reached", full_seen, 1'b1);
    chk("R8 b2 writes dropped while full", (new2 < 12), 1'b1);
    chk("R8 b2 write count", nlw2, new2);
    chk("R8 b2 read count", nlr2, ner2);
    chk("R8 b4 write count", nlw4, new4);
    chk("R8 b4 read count", nlr4, ner4);
    for (int i = 0; i < 16; i++) begin
      if (i < new2 && i < nlw2) chk("R8 b2 write order", lw2[i], ew2[i]);
      if (i < ner2 && i < nlr2) chk("R8 b2 read order", lr2[i], er2[i]);
      if (i < new4 && i < nlw4) chk("R8 b4 write order", lw4[i], ew4[i]);
      if (i < ner4 && i < nlr4) chk("R8 b4 read order", lr4[i], er4[i]);
    end
    chk("R9 b2 idle after drain", {rps2_n, wps2_n, br2, bf2}, 6'h3F);
    chk("R9 b4 idle after drain", {rps4_n, wps4_n, ar4}, 10'h300);
    chk("R8 flags low after drain", {wr_full2, rd_full2, wr_full4, rd_full4}, 4'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule